// File: doc/BRIEF.md
# Dual Saturating Fractional Accumulator

This block is the accumulate stage of a signal-processing datapath. It holds two 40-bit signed accumulators, A and B. On each clock it performs one operation on the accumulator picked by a select input. An external 40-bit operand can be loaded into it, added to it or subtracted from it, after a barrel shift of up to 16 places in either direction. Three further operations need no operand: adding the other accumulator, subtracting the other accumulator, or negating itself. The result can be clamped at a 40-bit limit or at a 32-bit limit.

A separate combinational store path turns either accumulator into a 16-bit signed fraction (1.15) for writing to memory. It can truncate, round half-up, or round half-to-even, and it can clamp the 16-bit result. The store path never changes the accumulator it reads. Per-accumulator sticky flags record wide-range overflow and saturation. An optional one-cycle error request reports operations that overflowed.

Top module: `fracacc_unit`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, both accumulators read 0, all four flags read 0 and `arith_err_o` reads 0.
- R2: Operation codes change the selected accumulator only; the other one keeps its value. The codes are 0 no-op, 1 add shifted operand, 2 subtract shifted operand, 3 load shifted operand, 4 add other accumulator, 5 subtract other accumulator, 6 negate, 7 clear flags. Select 0 picks A and select 1 picks B. The result is visible after the next rising clock edge.
- R3: The operand shifter shifts left when `shift_right_i` is 0, dropping bits above bit 39. It shifts arithmetically right when `shift_right_i` is 1. Shift amounts above 16 act as 16.
- R4: Code 4 writes sel+other, code 5 writes sel−other, and code 6 writes 0−sel. All are computed on 41-bit sign-extended values.
- R5: With `sat_en_i` at 0, the result written is the low 40 bits of the exact sum.
- R6: With `sat_en_i` at 1 and `sat_narrow_i` at 1, a result outside [−2^31, 2^31−1] is written as 0x007FFFFFFF if positive or 0xFF80000000 if negative. With `sat_narrow_i` at 0, a result outside the 40-bit range is written as 0x7FFFFFFFFF or 0x8000000000.
- R7: The overflow flag of the written accumulator is set when bits 39..31 of the unclamped 40-bit result are not all equal. It stays set until cleared.
- R8: The saturation flag of the written accumulator is set when the exact result does not fit in 40 bits, or when a clamp was applied. It stays set until cleared. Code 7 clears both flags of the selected accumulator only.
- R9: `arith_err_o` is high for exactly the cycle after a writing operation that detected overflow or saturation while `err_en_i` was 1. Otherwise it is low.
- R10: With `round_en_i` at 0, `store_o` is bits 31..16 of the accumulator picked by `store_sel_i`.
- R11: With `round_en_i` at 1 and `round_conv_i` at 0, 0x8000 is added to the accumulator before bits 31..16 are taken.
- R12: With `round_en_i` at 1 and `round_conv_i` at 1, rounding is the same as in R11, except when bits 15..0 equal exactly 0x8000 and bit 16 is 0. In that case the value is truncated.
- R13: With `store_sat_i` at 1, a rounded value outside the signed 32-bit range gives 0x7FFF if positive or 0x8000 if negative. The store path never changes any accumulator.
- R14: A no-op leaves both accumulators and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| acc_sel_i | input | 1 | Target accumulator (0 = A, 1 = B) |
| operand_i | input | 40 | Signed external operand |
| shift_amt_i | input | 5 | Shift distance, clamped to 16 |
| shift_right_i | input | 1 | 1 = arithmetic right shift, 0 = left shift |
| sat_en_i | input | 1 | Enable result clamping |
| sat_narrow_i | input | 1 | 1 = 32-bit clamp limits, 0 = 40-bit clamp limits |
| err_en_i | input | 1 | Enable the arithmetic error request |
| store_sel_i | input | 1 | Accumulator read by the store path |
| round_en_i | input | 1 | Enable rounding on store |
| round_conv_i | input | 1 | 1 = round half to even, 0 = round half up |
| store_sat_i | input | 1 | Clamp the 16-bit store value |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_a_o | output | 1 | Sticky overflow flag of A |
| ovf_b_o | output | 1 | Sticky overflow flag of B |
| satf_a_o | output | 1 | Sticky saturation flag of A |
| satf_b_o | output | 1 | Sticky saturation flag of B |
| arith_err_o | output | 1 | One-cycle arithmetic error request |
| store_o | output | 16 | Rounded or truncated, optionally clamped 1.15 value |

## Verification
Two functions can act in the same cycle: an overflowing accumulate into one accumulator, and a rounded, clamped store read of the accumulator that was just written. The bench provokes this by placing accumulators near the 32-bit and 40-bit limits. It then adds or subtracts small operands under every clamp mode. After each edge it compares the new accumulator, the flags and the error pulse with arithmetic computed in the bench. It then sweeps every rounding and store-clamp setting over the same state. A store setting counts as correct only if it changes `store_o` as expected and leaves both accumulators bit-identical.

// File: rtl/fracacc_pkg.sv
package fracacc_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_LOAD = 3'd3,
    OP_XADD = 3'd4,
    OP_XSUB = 3'd5,
    OP_NEG  = 3'd6,
    OP_CLRF = 3'd7
  } acc_op_e;

endpackage

// File: rtl/fracacc_shift.sv
module fracacc_shift #(
  parameter int W      = 40,
  parameter int AMT_W  = 5,
  parameter int MAX_SH = 16
) (
  input  logic [W-1:0]     data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             right_i,
  output logic [W-1:0]     data_o
);

  localparam logic [AMT_W-1:0] LIMIT = AMT_W'(MAX_SH);

  logic [AMT_W-1:0] eff;
  logic [W-1:0]     stg [AMT_W+1];

  assign eff    = (amt_i > LIMIT) ? LIMIT : amt_i;
  assign stg[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    logic [W-1:0] sra_v;
    logic [W-1:0] sll_v;
    assign sra_v      = W'($signed(stg[k]) >>> (2**k));
    assign sll_v      = stg[k] << (2**k);
    assign stg[k+1]   = eff[k] ? (right_i ? sra_v : sll_v) : stg[k];
  end

  assign data_o = stg[AMT_W];

endmodule

// File: rtl/fracacc_addsat.sv
module fracacc_addsat #(
  parameter int W      = 40,
  parameter int NARROW = 32
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] opnd_i,
  input  logic         sub_i,
  input  logic         sat_en_i,
  input  logic         sat_narrow_i,
  output logic [W-1:0] res_o,
  output logic         oa_det_o,
  output logic         sa_det_o
);

  localparam int TOPB = W - NARROW + 1;
  localparam logic [W-1:0] POS_WIDE   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_WIDE   = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] POS_NARROW = {{TOPB{1'b0}}, {(NARROW-1){1'b1}}};
  localparam logic [W-1:0] NEG_NARROW = {{TOPB{1'b1}}, {(NARROW-1){1'b0}}};

  logic [W:0]          sum;
  logic [W-1:0]        wrapped;
  logic [W-NARROW:0]   guard_w;
  logic [W-NARROW+1:0] guard_n;
  logic                ovf_wide;
  logic                ovf_narrow;
  logic                clamp;

  always_comb begin
    if (sub_i) sum = {src_i[W-1], src_i} - {opnd_i[W-1], opnd_i};
    else       sum = {src_i[W-1], src_i} + {opnd_i[W-1], opnd_i};
    wrapped    = sum[W-1:0];
    guard_w    = wrapped[W-1:NARROW-1];
    guard_n    = sum[W:NARROW-1];
    ovf_wide   = sum[W] ^ sum[W-1];
    ovf_narrow = !((&guard_n) || !(|guard_n));
    oa_det_o   = !((&guard_w) || !(|guard_w));
    clamp      = sat_en_i && (sat_narrow_i ? ovf_narrow : ovf_wide);
    sa_det_o   = ovf_wide || clamp;
    if (!clamp)            res_o = wrapped;
    else if (sat_narrow_i) res_o = sum[W] ? NEG_NARROW : POS_NARROW;
    else                   res_o = sum[W] ? NEG_WIDE : POS_WIDE;
  end

endmodule

// File: rtl/fracacc_store.sv
module fracacc_store #(
  parameter int W      = 40,
  parameter int NARROW = 32,
  parameter int OUT_W  = 16
) (
  input  logic [W-1:0]     acc_i,
  input  logic             rnd_en_i,
  input  logic             rnd_conv_i,
  input  logic             sat_i,
  output logic [OUT_W-1:0] word_o,
  output logic             ovf_o
);

  localparam int LSB = NARROW - OUT_W;
  localparam logic [LSB-1:0] HALF = {1'b1, {(LSB-1){1'b0}}};
  localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

  logic             tie;
  logic             add_half;
  logic [W:0]       rounded;
  logic [W-NARROW+1:0] guard;

  always_comb begin
    tie      = (acc_i[LSB-1:0] == HALF);
    add_half = rnd_en_i && !(rnd_conv_i && tie && !acc_i[LSB]);
    rounded  = {acc_i[W-1], acc_i} + (add_half ? (W+1)'(HALF) : '0);
    guard    = rounded[W:NARROW-1];
    ovf_o    = !((&guard) || !(|guard));
    if (sat_i && ovf_o) word_o = rounded[W] ? NEG_LIM : POS_LIM;
    else                word_o = rounded[NARROW-1:LSB];
  end

endmodule

// File: rtl/fracacc_unit.sv
module fracacc_unit #(
  parameter int ACC_W    = 40,
  parameter int NARROW_W = 32,
  parameter int STORE_W  = 16,
  parameter int SH_AMT_W = 5,
  parameter int SH_MAX   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op_i,
  input  logic                acc_sel_i,
  input  logic [ACC_W-1:0]    operand_i,
  input  logic [SH_AMT_W-1:0] shift_amt_i,
  input  logic                shift_right_i,
  input  logic                sat_en_i,
  input  logic                sat_narrow_i,
  input  logic                err_en_i,
  input  logic                store_sel_i,
  input  logic                round_en_i,
  input  logic                round_conv_i,
  input  logic                store_sat_i,
  output logic [ACC_W-1:0]    acc_a_o,
  output logic [ACC_W-1:0]    acc_b_o,
  output logic                ovf_a_o,
  output logic                ovf_b_o,
  output logic                satf_a_o,
  output logic                satf_b_o,
  output logic                arith_err_o,
  output logic [STORE_W-1:0]  store_o
);
  import fracacc_pkg::*;

  localparam int N_ACC = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  acc_op_e          op;
  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [ACC_W-1:0] acc_d [N_ACC];
  logic [N_ACC-1:0] oa_q, oa_d, sa_q, sa_d, acc_en;
  logic             err_d, err_q;
  logic [ACC_W-1:0] shifted, src, opnd, res;
  logic             sub, wr_en, clr, oa_det, sa_det;

  assign op = acc_op_e'(op_i);

  fracacc_shift #(.W(ACC_W), .AMT_W(SH_AMT_W), .MAX_SH(SH_MAX)) u_shift (
    .data_i  (operand_i),
    .amt_i   (shift_amt_i),
    .right_i (shift_right_i),
    .data_o  (shifted)
  );

  always_comb begin
    src   = acc_q[acc_sel_i];
    opnd  = shifted;
    sub   = 1'b0;
    wr_en = 1'b1;
    clr   = 1'b0;
    case (op)
      OP_ADD:  ;
      OP_SUB:  sub = 1'b1;
      OP_LOAD: src = '0;
      OP_XADD: opnd = acc_q[!acc_sel_i];
      OP_XSUB: begin opnd = acc_q[!acc_sel_i]; sub = 1'b1; end
      OP_NEG:  begin src = '0; opnd = acc_q[acc_sel_i]; sub = 1'b1; end
      OP_CLRF: begin wr_en = 1'b0; clr = 1'b1; end
      default: wr_en = 1'b0;
    endcase
  end

  fracacc_addsat #(.W(ACC_W), .NARROW(NARROW_W)) u_addsat (
    .src_i        (src),
    .opnd_i       (opnd),
    .sub_i        (sub),
    .sat_en_i     (sat_en_i),
    .sat_narrow_i (sat_narrow_i),
    .res_o        (res),
    .oa_det_o     (oa_det),
    .sa_det_o     (sa_det)
  );

  // next state
  always_comb begin
    for (int i = 0; i < N_ACC; i++) begin
      acc_en[i] = wr_en && (acc_sel_i == i[0]);
      acc_d[i]  = acc_en[i] ? res : acc_q[i];
      if (clr && (acc_sel_i == i[0])) begin
        oa_d[i] = 1'b0;
        sa_d[i] = 1'b0;
      end else begin
        oa_d[i] = oa_q[i] | (acc_en[i] & oa_det);
        sa_d[i] = sa_q[i] | (acc_en[i] & sa_det);
      end
    end
    err_d = wr_en && err_en_i && (oa_det || sa_det);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
      oa_q  <= '0;
      sa_q  <= '0;
      err_q <= 1'b0;
    end else begin
      for (int i = 0; i < N_ACC; i++) begin
        if (acc_en[i]) acc_q[i] <= acc_d[i];
      end
      oa_q  <= oa_d;
      sa_q  <= sa_d;
      err_q <= err_d;
    end
  end

  logic store_ovf;

  fracacc_store #(.W(ACC_W), .NARROW(NARROW_W), .OUT_W(STORE_W)) u_store (
    .acc_i      (acc_q[store_sel_i]),
    .rnd_en_i   (round_en_i),
    .rnd_conv_i (round_conv_i),
    .sat_i      (store_sat_i),
    .word_o     (store_o),
    .ovf_o      (store_ovf)
  );

  assign acc_a_o     = acc_q[0];
  assign acc_b_o     = acc_q[1];
  assign ovf_a_o     = oa_q[0];
  assign ovf_b_o     = oa_q[1];
  assign satf_a_o    = sa_q[0];
  assign satf_b_o    = sa_q[1];
  assign arith_err_o = err_q;

  AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i != 3'd0 && !acc_sel_i) |=> $stable(acc_b_o)); // R2
  AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == 3'd0) |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(oa_q) && $stable(sa_q))); // R14
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i inside {[3'd1:3'd6]} && !acc_sel_i && sat_en_i && sat_narrow_i)
      |=> ((&acc_a_o[ACC_W-1:NARROW_W-1]) || !(|acc_a_o[ACC_W-1:NARROW_W-1]))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ovf_a_o) |-> ($past(op_i) == 3'd7 && !$past(acc_sel_i))); // R7
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(satf_b_o) |-> ($past(op_i) == 3'd7 && $past(acc_sel_i))); // R8
  AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_ni)
    arith_err_o |-> $past(err_en_i)); // R9
  AST_STORE_CLAMP: assert property (@(posedge clk) disable iff (!rst_ni)
    (store_sat_i && store_ovf) |-> (store_o == {1'b0, {(STORE_W-1){1'b1}}} ||
                                    store_o == {1'b1, {(STORE_W-1){1'b0}}})); // R13

endmodule

// File: tb/fracacc_unit_tb_top.sv
module fracacc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic        acc_sel_i;
  logic [39:0] operand_i;
  logic [4:0]  shift_amt_i;
  logic        shift_right_i, sat_en_i, sat_narrow_i, err_en_i;
  logic        store_sel_i, round_en_i, round_conv_i, store_sat_i;
  logic [39:0] acc_a_o, acc_b_o;
  logic        ovf_a_o, ovf_b_o, satf_a_o, satf_b_o, arith_err_o;
  logic [15:0] store_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [39:0] macc [2];
  bit          moa [2];
  bit          msa [2];
  bit          merr;

  always #10 clk = ~clk;

  fracacc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_sel_i(acc_sel_i),
    .operand_i(operand_i), .shift_amt_i(shift_amt_i), .shift_right_i(shift_right_i),
    .sat_en_i(sat_en_i), .sat_narrow_i(sat_narrow_i), .err_en_i(err_en_i),
    .store_sel_i(store_sel_i), .round_en_i(round_en_i), .round_conv_i(round_conv_i),
    .store_sat_i(store_sat_i), .acc_a_o(acc_a_o), .acc_b_o(acc_b_o),
    .ovf_a_o(ovf_a_o), .ovf_b_o(ovf_b_o), .satf_a_o(satf_a_o), .satf_b_o(satf_b_o),
    .arith_err_o(arith_err_o), .store_o(store_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint sx(logic [39:0] v);
    return longint'({{24{v[39]}}, v});
  endfunction

  function automatic logic [39:0] m_shift(logic [39:0] d, int amt, bit right);
    int e = (amt > 16) ? 16 : amt;
    if (right) return 40'($signed(d) >>> e);
    return d << e;
  endfunction

  function automatic logic [15:0] m_store(logic [39:0] a, bit rnd, bit conv, bit sat);
    longint v = sx(a);
    bit tie = (a[15:0] == 16'h8000);
    bit ovf;
    if (rnd && !(conv && tie && !a[16])) v = v + 32768;
    ovf = (v > 64'sd2147483647) || (v < -64'sd2147483648);
    if (sat && ovf) return (v < 0) ? 16'h8000 : 16'h7FFF;
    return v[31:16];
  endfunction

  task automatic check_state(string req);
    chk({req, " accA"}, 64'(acc_a_o), 64'(macc[0]));
    chk({req, " accB"}, 64'(acc_b_o), 64'(macc[1]));
    chk({req, " flags"}, 64'({ovf_a_o, ovf_b_o, satf_a_o, satf_b_o}),
        64'({moa[0], moa[1], msa[0], msa[1]}));
    chk({req, " err"}, 64'(arith_err_o), 64'(merr));
  endtask

  // drives one operation at a falling edge and checks one cycle later
  task automatic run_op(string req, int op, bit sel, logic [39:0] opnd, int amt, bit right,
                        bit sen, bit snar, bit een);
    longint a_v, o_v, s_v, t;
    logic [39:0] wrapped, res;
    bit oa, ovf41, in32, clamp, sa;
    op_i = 3'(op); acc_sel_i = sel; operand_i = opnd; shift_amt_i = 5'(amt);
    shift_right_i = right; sat_en_i = sen; sat_narrow_i = snar; err_en_i = een;
    a_v = sx(macc[sel]); o_v = sx(macc[!sel]); s_v = sx(m_shift(opnd, amt, right));
    case (op)
      1: t = a_v + s_v;
      2: t = a_v - s_v;
      3: t = s_v;
      4: t = a_v + o_v;
      5: t = a_v - o_v;
      6: t = -a_v;
      default: t = 0;
    endcase
    wrapped = t[39:0];
    oa    = !((&wrapped[39:31]) || !(|wrapped[39:31]));
    ovf41 = (t > 64'sd549755813887) || (t < -64'sd549755813888);
    in32  = (t <= 64'sd2147483647) && (t >= -64'sd2147483648);
    clamp = sen && (snar ? !in32 : ovf41);
    sa    = ovf41 || clamp;
    if (!clamp)    res = wrapped;
    else if (snar) res = (t < 0) ? 40'hFF80000000 : 40'h007FFFFFFF;
    else           res = (t < 0) ? 40'h8000000000 : 40'h7FFFFFFFFF;
    @(posedge clk);
    @(negedge clk);
    merr = 1'b0;
    if (op >= 1 && op <= 6) begin
      macc[sel] = res;
      moa[sel]  = moa[sel] | oa;
      msa[sel]  = msa[sel] | sa;
      merr      = een && (oa || sa);
    end else if (op == 7) begin
      moa[sel] = 1'b0;
      msa[sel] = 1'b0;
    end
    check_state(req);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] vals [8];
    logic [39:0] bases [4];
    logic [39:0] smalls [2];
    rst_n = 1'b0;
    op_i = '0; acc_sel_i = 0; operand_i = 40'h12_3456_789A; shift_amt_i = 0;
    shift_right_i = 0; sat_en_i = 0; sat_narrow_i = 0; err_en_i = 0;
    store_sel_i = 0; round_en_i = 0; round_conv_i = 0; store_sat_i = 0;
    for (int i = 0; i < 2; i++) begin macc[i] = '0; moa[i] = 0; msa[i] = 0; end
    merr = 0;
    repeat (3) @(negedge clk);
    check_state("R1 in reset");
    chk("R1 store", 64'(store_o), 64'h0);
    rst_n = 1'b1;
    op_i = 3'd0;
    repeat (3) @(negedge clk);
    check_state("R1 after release");

    // R3 shifter sweep, both directions, both targets
    for (int d = 0; d < 2; d++) begin
      for (int amt = 0; amt <= 20; amt++) begin
        run_op("R3 shift into A", 3, 0, 40'h80_0000_1235, amt, d[0], 0, 0, 0);
        run_op("R3 shift into B", 3, 1, 40'hF0_1234_5678, amt, d[0], 0, 0, 0);
      end
    end

    // R2 operand add and subtract on each accumulator
    vals[0] = 40'h00_0000_0001; vals[1] = 40'hFF_FFFF_FFFF; vals[2] = 40'h00_1234_5678;
    vals[3] = 40'h00_7FFF_0000; vals[4] = 40'hFF_8000_0000; vals[5] = 40'h3F_0000_0000;
    vals[6] = 40'hC0_0000_0001; vals[7] = 40'h00_0000_8000;
    for (int i = 0; i < 8; i++) begin
      run_op("R2 add to A", 1, 0, vals[i], i, 0, 0, 0, 0);
      run_op("R2 sub from B", 2, 1, vals[7-i], i, 1, 0, 0, 0);
    end

    // R4 accumulator-to-accumulator
    run_op("R4 load A", 3, 0, 40'h00_1111_2222, 0, 0, 0, 0, 0);
    run_op("R4 load B", 3, 1, 40'hFF_F000_0003, 0, 0, 0, 0, 0);
    run_op("R4 xadd A", 4, 0, 40'h0, 0, 0, 0, 0, 0);
    run_op("R4 xsub B", 5, 1, 40'h0, 0, 0, 0, 0, 0);
    run_op("R4 neg A", 6, 0, 40'h0, 0, 0, 0, 0, 0);
    run_op("R4 neg B", 6, 1, 40'h0, 0, 0, 0, 0, 0);
    run_op("R4 load min", 3, 0, 40'h80_0000_0000, 0, 0, 0, 0, 0);
    run_op("R5 neg min wraps", 6, 0, 40'h0, 0, 0, 0, 0, 1);
    run_op("R6 neg min clamps", 6, 0, 40'h0, 0, 0, 1, 0, 1);

    // R8 clear only the selected flags; R14 no-op holds
    run_op("R8 set B flags", 3, 1, 40'h40_0000_0000, 1, 0, 0, 0, 0);
    run_op("R8 clear A", 7, 0, 40'h0, 0, 0, 0, 0, 0);
    run_op("R14 nop", 0, 1, 40'hFF_FFFF_FFFF, 7, 1, 1, 1, 1);
    run_op("R8 clear B", 7, 1, 40'h0, 0, 0, 0, 0, 0);

    // R5 R6 R7 R8 R9 limit sweep under every clamp mode
    bases[0] = 40'h00_7FFF_FFF0; bases[1] = 40'h7F_FFFF_FFF0;
    bases[2] = 40'h80_0000_0010; bases[3] = 40'hFF_8000_0010;
    smalls[0] = 40'h00_0000_0020; smalls[1] = 40'hFF_FFFF_FFE0;
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 4; b++) begin
        for (int s = 0; s < 2; s++) begin
          for (int o = 1; o <= 2; o++) begin
            bit sel = bit'(b[0] ^ s[0]);
            run_op("R8 clear", 7, sel, 40'h0, 0, 0, 0, 0, 0);
            run_op("R5 preload", 3, sel, bases[b], 0, 0, 0, 0, 0);
            run_op("R6 R7 R9 limit op", o, sel, smalls[s], 0, 0, m[0], m[1], bit'(b[1]));
            run_op("R9 quiet", 0, sel, 40'h0, 0, 0, 0, 0, 1);
          end
        end
      end
    end

    // R10-R13 store path over every mode; accumulators must not move
    vals[0] = 40'h00_1234_8000; vals[1] = 40'h00_1235_8000; vals[2] = 40'h00_1234_7FFF;
    vals[3] = 40'h00_1234_8001; vals[4] = 40'h00_7FFF_8000; vals[5] = 40'h00_FFFF_0000;
    vals[6] = 40'hFF_7FFF_0000; vals[7] = 40'hFF_FFFF_8000;
    for (int i = 0; i < 8; i++) begin
      run_op("R13 preload", 3, bit'(i[0]), vals[i], 0, 0, 0, 0, 0);
      for (int mode = 0; mode < 8; mode++) begin
        store_sel_i = bit'(i[0]);
        round_en_i = mode[0]; round_conv_i = mode[1]; store_sat_i = mode[2];
        #1;
        if (!mode[0])     chk("R10 truncate store", 64'(store_o), 64'(m_store(vals[i], 0, 0, mode[2])));
        else if (!mode[1]) chk("R11 half-up store", 64'(store_o), 64'(m_store(vals[i], 1, 0, mode[2])));
        else              chk("R12 half-even store", 64'(store_o), 64'(m_store(vals[i], 1, 1, mode[2])));
        op_i = 3'd0;
        @(posedge clk);
        @(negedge clk);
        merr = 0;
        check_state("R13 store leaves accumulators");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule